// File: doc/BRIEF.md
# Serial Transmitter with Inter-Character Guard Time

This block sends bytes on an asynchronous serial line. Each character leaves as a low start bit, the data bits least significant first, an optional parity bit and a high stop bit. After the stop bit the line stays high for a programmable number of bit periods, the guard time, before another start bit may begin. The guard time counts as part of the character that has just been sent. The block therefore reports itself empty only after the guard time has run out.

A client offers bytes through a valid/ready write port. The block keeps one waiting byte in a holding register and sends from a shift stage. The write-ready output doubles as the "holding register free" flag. A one-cycle bit-rate tick from outside sets the bit period. Every bit boundary and every guard-time count happens on that tick.

Top module: `uart_tg_tx`

## Requirements
- R1: After reset, txd is high (idle), wr_ready is high and tx_empty is high.
- R2: A character is sent as txd=0 for the start bit, then data bits 0 to 7 in that order (LSB first), then the parity bit when enabled, then txd=1 for the stop bit. Each bit lasts exactly one tick period, and the start bit begins on the first tick after the byte is accepted or released.
- R3: With parity_en=1 the parity bit is even: it equals the XOR of the eight data bits.
- R4: With parity_en=0 no parity slot is sent, and the stop bit directly follows data bit 7 (ten bit periods per character).
- R5: With guard_len=G>0, txd stays high for exactly G tick periods after the stop bit. A waiting byte's start bit begins at the tick that ends the gap.
- R6: With guard_len=0 a waiting byte's start bit follows the stop bit with no idle period.
- R7: guard_len=255, the largest value, yields a gap of 255 bit periods.
- R8: An accepted write (wr_valid and wr_ready high at a clock edge) drops wr_ready in the next cycle. wr_ready rises again when the byte moves to the shift stage, at the tick that begins its start bit.
- R9: tx_empty is low from the accepted write until the guard time of the last character has ended, and it is high only when no byte waits, no frame is in progress and the guard count is zero.
- R10: A byte written during the guard time waits in the holding register and starts only when the gap ends.
- R11: txd changes only in the cycle after a clock edge at which bit_tick was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| wr_valid | input | 1 | Byte offered for sending |
| wr_data | input | DATA_BITS | Byte to send |
| wr_ready | output | 1 | Holding register free; a write is taken when both valid and ready are high |
| parity_en | input | 1 | 1 adds an even parity bit to each character |
| guard_len | input | GUARD_W | Idle bit periods inserted after each stop bit |
| txd | output | 1 | Serial line, high when idle |
| tx_empty | output | 1 | Nothing held, nothing shifting, guard time over |

## Verification
The hardest case to reach is a byte that arrives while the guard time is already counting. The holding register must be empty then, so the write has to come after the previous byte has left it but before the gap ends. The bench sends one byte and waits until the per-tick line log shows the stop bit is past. It then writes the second byte with several gap ticks still left and checks that the new start bit lands exactly at the end of the programmed gap. The 0-length and 255-length gap extremes are also driven with a second byte queued behind the first.

// File: rtl/uart_tg_pkg.sv
package uart_tg_pkg;
   typedef enum logic [2:0] {
      TX_IDLE   = 3'd0,
      TX_START  = 3'd1,
      TX_DATA   = 3'd2,
      TX_PARITY = 3'd3,
      TX_STOP   = 3'd4
   } tx_state_e;
endpackage

// File: rtl/uart_tg_hold.sv
module uart_tg_hold #(
   parameter int DATA_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_valid,
   input  logic [DATA_BITS-1:0] wr_data,
   output logic                 wr_ready,
   input  logic                 take,
   output logic                 full,
   output logic [DATA_BITS-1:0] data
);
   logic accept;

   assign wr_ready = !full;
   assign accept   = wr_valid && !full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full <= 1'b0;
         data <= '0;
      end else if (accept) begin
         full <= 1'b1;
         data <= wr_data;
      end else if (take) begin
         full <= 1'b0;
      end
   end

   assert_ready_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready) |=> !wr_ready);

   assert_held_byte_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !take) |=> (full && $stable(data)));
endmodule

// File: rtl/uart_tg_guard.sv
module uart_tg_guard #(
   parameter int GUARD_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               arm,
   input  logic [GUARD_W-1:0] len,
   output logic               open,
   output logic               done
);
   logic [GUARD_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (arm)
         cnt <= len;
      else if (tick && cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign open = (cnt <= GUARD_W'(1));
   assign done = (cnt == '0);

   assert_count_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick) |=> $stable(cnt));
endmodule

// File: rtl/uart_tg_shift.sv
module uart_tg_shift
   import uart_tg_pkg::*;
#(
   parameter int DATA_BITS  = 8,
   parameter bit PARITY_ODD = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 hold_full,
   input  logic [DATA_BITS-1:0] hold_data,
   input  logic                 guard_open,
   input  logic                 len_zero,
   input  logic                 parity_en,
   output logic                 take,
   output logic                 arm,
   output logic                 txd,
   output logic                 busy
);
   localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_BITS - 1);

   tx_state_e            state;
   logic [DATA_BITS-1:0] shreg;
   logic [IDX_W-1:0]     bidx;
   logic                 par_bit;

   generate
      if (PARITY_ODD) begin : g_odd
         assign par_bit = ~^shreg;
      end else begin : g_even
         assign par_bit = ^shreg;
      end
   endgenerate

   assign take = tick && hold_full &&
                 (((state == TX_IDLE) && guard_open) || ((state == TX_STOP) && len_zero));
   assign arm  = tick && (state == TX_STOP);
   assign busy = (state != TX_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= TX_IDLE;
         shreg <= '0;
         bidx  <= '0;
      end else if (take) begin
         state <= TX_START;
         shreg <= hold_data;
         bidx  <= '0;
      end else if (tick) begin
         case (state)
            TX_START: begin
               state <= TX_DATA;
               bidx  <= '0;
            end
            TX_DATA: begin
               if (bidx == LAST_IDX)
                  state <= parity_en ? TX_PARITY : TX_STOP;
               else
                  bidx <= bidx + 1'b1;
            end
            TX_PARITY: state <= TX_STOP;
            TX_STOP:   state <= TX_IDLE;
            default:   state <= TX_IDLE;
         endcase
      end
   end

   always_comb begin
      case (state)
         TX_START:  txd = 1'b0;
         TX_DATA:   txd = shreg[bidx];
         TX_PARITY: txd = par_bit;
         default:   txd = 1'b1;
      endcase
   end

   assert_line_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick) |=> $stable(txd));

   assert_start_after_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && state == TX_IDLE && !guard_open) |=> (state == TX_IDLE));
endmodule

// File: rtl/uart_tg_tx.sv
module uart_tg_tx #(
   parameter int DATA_BITS  = 8,
   parameter int GUARD_W    = 8,
   parameter bit PARITY_ODD = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bit_tick,
   input  logic                 wr_valid,
   input  logic [DATA_BITS-1:0] wr_data,
   output logic                 wr_ready,
   input  logic                 parity_en,
   input  logic [GUARD_W-1:0]   guard_len,
   output logic                 txd,
   output logic                 tx_empty
);
   generate
      if (DATA_BITS < 5 || DATA_BITS > 9) begin : g_bad_data
         $error("DATA_BITS must lie between 5 and 9");
      end
      if (GUARD_W < 1 || GUARD_W > 16) begin : g_bad_guard
         $error("GUARD_W must lie between 1 and 16");
      end
   endgenerate

   logic                 hold_full;
   logic [DATA_BITS-1:0] hold_data;
   logic                 take;
   logic                 arm;
   logic                 guard_open;
   logic                 guard_done;
   logic                 busy;

   uart_tg_hold #(.DATA_BITS(DATA_BITS)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_valid (wr_valid),
      .wr_data  (wr_data),
      .wr_ready (wr_ready),
      .take     (take),
      .full     (hold_full),
      .data     (hold_data)
   );

   uart_tg_guard #(.GUARD_W(GUARD_W)) u_guard (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (bit_tick),
      .arm   (arm),
      .len   (guard_len),
      .open  (guard_open),
      .done  (guard_done)
   );

   uart_tg_shift #(.DATA_BITS(DATA_BITS), .PARITY_ODD(PARITY_ODD)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (bit_tick),
      .hold_full  (hold_full),
      .hold_data  (hold_data),
      .guard_open (guard_open),
      .len_zero   (guard_len == '0),
      .parity_en  (parity_en),
      .take       (take),
      .arm        (arm),
      .txd        (txd),
      .busy       (busy)
   );

   assign tx_empty = !hold_full && !busy && guard_done;

   assert_empty_means_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty |-> (txd && wr_ready));

   assert_write_clears_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready) |=> !tx_empty);
endmodule

// File: tb/uart_tg_tx_test.sv
`timescale 1ns/1ps
module uart_tg_tx_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_tick = 1'b0;
   logic       wr_valid = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       parity_en = 1'b1;
   logic [7:0] guard_len = 8'd0;
   logic       wr_ready, txd, tx_empty;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   bit line_q [4096];
   bit rdy_q  [4096];
   bit emp_q  [4096];
   int n_log = 0;
   int div = 0;
   int off_tick_changes = 0;
   logic last_txd = 1'b1;

   always #4 clk = ~clk;

   uart_tg_tx uut (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_valid(wr_valid),
      .wr_data(wr_data), .wr_ready(wr_ready), .parity_en(parity_en),
      .guard_len(guard_len), .txd(txd), .tx_empty(tx_empty)
   );

   always @(negedge clk) begin
      if (rst_n && txd !== last_txd && !bit_tick) off_tick_changes++;
      last_txd = txd;
      if (bit_tick && n_log < 4096) begin
         line_q[n_log] = txd;
         rdy_q[n_log]  = wr_ready;
         emp_q[n_log]  = tx_empty;
         n_log++;
      end
      div = (div == 3) ? 0 : div + 1;
      bit_tick = (div == 3);
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic put(input logic [7:0] d, output int base);
      @(negedge clk);
      while (!wr_ready) @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = d;
      @(posedge clk);
      base = n_log;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic wait_ticks(input int n);
      int target = n_log + n;
      while (n_log < target) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic wait_empty();
      @(negedge clk);
      while (!tx_empty) @(negedge clk);
      wait_ticks(2);
   endtask

   function automatic int find_start(input int from);
      for (int i = from; i < n_log; i++)
         if (!line_q[i]) return i;
      return -1;
   endfunction

   task automatic chk_frame(input int s, input logic [7:0] d, input bit par, input string tag);
      int k;
      chk(s >= 0 && line_q[s] == 1'b0, {tag, " R2 start"}, s, 0);
      if (s < 0) return;
      for (int b = 0; b < 8; b++)
         chk(line_q[s+1+b] == d[b], {tag, " R2 data bit"}, line_q[s+1+b], d[b]);
      k = s + 9;
      if (par) begin
         chk(line_q[k] == ^d, {tag, " R3 parity"}, line_q[k], ^d);
         k++;
      end
      chk(line_q[k] == 1'b1, {tag, par ? " R2 stop" : " R4 stop after D7"}, line_q[k], 1);
      chk(rdy_q[s] == 1'b1, {tag, " R8 ready back at start"}, rdy_q[s], 1);
   endtask

   task automatic t_reset();
      chk(txd == 1'b1, "R1 txd", txd, 1);
      chk(wr_ready == 1'b1, "R1 wr_ready", wr_ready, 1);
      chk(tx_empty == 1'b1, "R1 tx_empty", tx_empty, 1);
   endtask

   task automatic t_single();
      int base, s;
      parity_en = 1'b1; guard_len = 8'd0;
      put(8'hA5, base);
      chk(wr_ready == 1'b0, "R8 ready low after write", wr_ready, 0);
      chk(tx_empty == 1'b0, "R9 empty low after write", tx_empty, 0);
      wait_ticks(16);
      s = find_start(base);
      chk(s >= base && s <= base + 1, "R2 start timing", s, base);
      chk_frame(s, 8'hA5, 1'b1, "single");
      if (s >= 0) begin
         for (int i = s; i < s + 11; i++)
            chk(emp_q[i] == 1'b0, "R9 empty low in frame", emp_q[i], 0);
         chk(emp_q[s+11] == 1'b1, "R9 empty after frame", emp_q[s+11], 1);
      end
      wait_empty();
   endtask

   task automatic t_noparity_gap();
      int base, s;
      parity_en = 1'b0; guard_len = 8'd3;
      put(8'h3C, base);
      wait_ticks(18);
      s = find_start(base);
      chk_frame(s, 8'h3C, 1'b0, "nopar");
      if (s >= 0) begin
         for (int i = s + 10; i < s + 13; i++) begin
            chk(line_q[i] == 1'b1, "R5 line idle in gap", line_q[i], 1);
            chk(emp_q[i] == 1'b0, "R9 empty low in gap", emp_q[i], 0);
         end
         chk(emp_q[s+13] == 1'b1, "R9 empty after gap", emp_q[s+13], 1);
      end
      wait_empty();
   endtask

   task automatic t_pair(input logic [7:0] g, input bit par, input logic [7:0] d1,
                         input logic [7:0] d2, input string tag);
      int base, b2, s1, s2, len;
      parity_en = par; guard_len = g;
      len = par ? 11 : 10;
      put(d1, base);
      put(d2, b2);
      wait_ticks(2 * len + int'(g) + 4);
      s1 = find_start(base);
      s2 = (s1 >= 0) ? find_start(s1 + len) : -1;
      chk(s2 == s1 + len + int'(g), {tag, " second start offset"}, s2 - s1, len + int'(g));
      for (int i = s1 + len; i < s1 + len + int'(g); i++)
         chk(line_q[i] == 1'b1 && emp_q[i] == 1'b0, {tag, " R5 gap idle"}, line_q[i], 1);
      chk_frame(s1, d1, par, tag);
      chk_frame(s2, d2, par, tag);
      wait_empty();
   endtask

   task automatic t_write_in_gap();
      int base, b2, s1, s2;
      parity_en = 1'b1; guard_len = 8'd6;
      put(8'h80, base);
      wait_ticks(14);
      s1 = find_start(base);
      chk(s1 >= 0 && n_log > s1 + 11 && n_log < s1 + 17, "R10 write lands in gap", n_log, s1 + 13);
      chk(tx_empty == 1'b0, "R9 empty low while gap runs", tx_empty, 0);
      put(8'h01, b2);
      chk(wr_ready == 1'b0, "R10 byte held during gap", wr_ready, 0);
      wait_ticks(16);
      s2 = (s1 >= 0) ? find_start(s1 + 11) : -1;
      chk(s2 == s1 + 17, "R10 held byte starts at gap end", s2 - s1, 17);
      chk_frame(s2, 8'h01, 1'b1, "ingap R10");
      wait_empty();
   endtask

   task automatic t_max_gap();
      int base, s;
      parity_en = 1'b1; guard_len = 8'd255;
      put(8'hFF, base);
      wait_ticks(270);
      s = find_start(base);
      chk_frame(s, 8'hFF, 1'b1, "max R7");
      if (s >= 0) begin
         chk(emp_q[s+11+254] == 1'b0, "R7 empty low at last gap tick", emp_q[s+11+254], 0);
         chk(emp_q[s+11+255] == 1'b1, "R7 empty after 255 gap", emp_q[s+11+255], 1);
         chk(line_q[s+11+200] == 1'b1, "R7 line idle deep in gap", line_q[s+11+200], 1);
      end
      wait_empty();
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (5) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_single();
      t_noparity_gap();
      t_pair(8'd0, 1'b1, 8'h5A, 8'hC3, "R6 zero gap");
      t_pair(8'd5, 1'b1, 8'h0F, 8'hF0, "R5 gap five");
      t_pair(8'd255, 1'b0, 8'h96, 8'h69, "R7 max gap pair");
      t_write_in_gap();
      t_max_gap();
      chk(off_tick_changes == 0, "R11 txd moved off tick", off_tick_changes, 0);
      report();
   end

   initial begin
      #(8 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 1 expected 0");
      report();
   end
endmodule